// File: doc/BRIEF.md
# Serial Host Register Port

This block is the control-register front end of an audio transmitter. A host reaches an 8-bit register file over a four-signal serial link. The four signals are an active-low select, a serial clock, a data input and a data output with its own drive enable. Each access is one 16-bit frame. The register outputs set the transmitter's sample format, power and run state, source select, validity flag, output enable and channel-status bytes. Those outputs feed the neighbouring blocks directly.

The serial pins are synchronised into the master clock domain, and their edges are detected there. If the master clock stops, the register file cannot change. An active-low power-down input clears the port asynchronously and returns every register to its default. In the default four-signal mode the host can both read and write. A mode bit in the register file switches the port to write-only operation, and in that mode the data output is never driven.

Top module: `host_reg_port`

## Requirements
- R1: While `pdnN` is low, and after it rises, the registers hold their defaults: address 0 = 0x8F, address 3 = 0x81, address 4 = 0x04, and every other address = 0x00.
- R2: The frame is 16 bits, sampled on rising `sclk` edges while `csN` is low, in this order:
  - a 2-bit chip code;
  - a direction bit, where 1 means write and 0 means read;
  - a 5-bit address, MSB first;
  - 8 data bits, MSB first.
  
  In normal mode, a frame with chip code 11 and direction 1 writes the data to the address.
- R3: A write takes effect only on the 16th rising `sclk` edge after `csN` falls. A frame cut short by `csN` rising earlier changes no register.
- R4: In a normal-mode read (chip code 11, direction 0), `sdoOe` rises after the falling edge that follows the 8th rising edge. On that edge and on the next seven falling edges, `sdo` presents the addressed byte MSB first. The last bit is held until `csN` rises, and `sdo` changes only on falling edges.
- R5: `sdoOe` is low while `pdnN` is low, while `csN` is high, during any write frame, and before the 8th falling edge of a read.
- R6: A frame whose chip code is not 11 is ignored. It writes nothing and never raises `sdoOe`.
- R7: When bit 2 of address 2 is 1 (write-only mode), the following hold:
  - a write commits only when the first three bits are 011;
  - a header of 111 is ignored;
  - reads never raise `sdoOe`.
- R8: Address 1 and addresses 10 to 31 cannot be written, and a read of any of them returns 0x00.
- R9: Clearing bit 0 of address 0 lowers `runN` and leaves every other register unchanged. Later writes are still accepted.
- R10: Pulling `pdnN` low in the middle of a frame at once drops `sdoOe` and restores the defaults. Frames sent while `pdnN` is low change nothing.
- R11: The register fields map to the outputs as follows:
  - `fmtSel` = address 0 bits 3:2;
  - `powerOn` = address 0 bit 1;
  - `runN` = address 0 bit 0;
  - `wireMode3` = address 2 bit 2;
  - `inSel` = address 2 bits 1:0;
  - `validity` = address 3 bit 1;
  - `txEnable` = address 3 bit 0;
  - `chanStatus[8k+7:8k]` = address 4+k.
- R12: Rising `sclk` edges after the 16th, while `csN` stays low, have no effect. They cause no second write and no shift of the data already committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all state is sampled on it |
| pdnN | input | 1 | Asynchronous active-low power-down and register reset |
| csN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data |
| sdoOe | output | 1 | Drive enable for `sdo`; low means high impedance |
| fmtSel | output | 2 | Audio input format select |
| powerOn | output | 1 | Transmitter power enable |
| runN | output | 1 | Soft reset of transmitter timing; 0 holds it in reset |
| wireMode3 | output | 1 | Write-only port mode |
| inSel | output | 2 | Audio source select |
| validity | output | 1 | Validity flag to transmit |
| txEnable | output | 1 | Transmit output enable |
| chanStatus | output | 48 | Six channel-status bytes, address 4 in the low byte |

## Verification
The assertions assume that `sclk` and `csN` each stay steady for several master-clock cycles between edges. With that assumption, every synchronised edge is seen exactly once and the frame counter cannot skip a bit. They also assume that the host raises `csN` between frames, so each frame starts from a cleared counter and a quiet output.

The stimulus meets both assumptions by construction. It holds each `sclk` phase for eight master clocks, changes `sdi` only while `sclk` is low, and always ends a frame by raising `csN` before the next begins. The one exception is the power-down test. That test deliberately leaves `csN` low while `pdnN` falls.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

  // Strobes from the frame sequencer to the register datapath.
  typedef struct packed {
    logic clear;     // select inactive: abandon frame
    logic bitIn;     // synchronised serial data bit
    logic shiftIn;   // accept bitIn into the frame shifter
    logic atHeader;  // this shift completes the header
    logic atEnd;     // this shift completes the frame
    logic outStart;  // first falling edge of the data phase
    logic outShift;  // later falling edges of the data phase
  } hrpStrobe_t;

  localparam logic [1:0] CHIP_CODE      = 2'b11;
  localparam logic [2:0] WRONLY_HEADER  = 3'b011;

  function automatic logic [7:0] regDefault(input int idx);
    case (idx)
      0:       return 8'h8F;
      3:       return 8'h81;
      4:       return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/hrp_ctrl.sv
module hrp_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 16,
  parameter int HEADER_BITS = 8
) (
  input  logic               clk,
  input  logic               pdnN,
  input  logic               csN,
  input  logic               sclk,
  input  logic               sdi,
  output hrp_pkg::hrpStrobe_t strobe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HEADER_BITS);

  logic [SYNC_STAGES-1:0] csPipe, clkPipe, datPipe;
  logic                   clkLast;
  logic [CNT_W-1:0]       bitCnt;
  logic                   csIdle, clkNow, riseEdge, fallEdge, canShift;

  always_ff @(posedge clk or negedge pdnN) begin
    if (!pdnN) begin
      csPipe  <= '1;
      clkPipe <= '0;
      datPipe <= '0;
      clkLast <= 1'b0;
    end else begin
      csPipe  <= {csPipe[SYNC_STAGES-2:0], csN};
      clkPipe <= {clkPipe[SYNC_STAGES-2:0], sclk};
      datPipe <= {datPipe[SYNC_STAGES-2:0], sdi};
      clkLast <= clkNow;
    end
  end

  assign csIdle   = csPipe[SYNC_STAGES-1];
  assign clkNow   = clkPipe[SYNC_STAGES-1];
  assign riseEdge = clkNow & ~clkLast;
  assign fallEdge = ~clkNow & clkLast;
  assign canShift = ~csIdle & riseEdge & (bitCnt < CNT_FULL);

  always_ff @(posedge clk or negedge pdnN) begin
    if (!pdnN)         bitCnt <= '0;
    else if (csIdle)   bitCnt <= '0;
    else if (canShift) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobe          = '0;
    strobe.clear    = csIdle;
    strobe.bitIn    = datPipe[SYNC_STAGES-1];
    strobe.shiftIn  = canShift;
    strobe.atHeader = canShift && (bitCnt == CNT_HDR - 1'b1);
    strobe.atEnd    = canShift && (bitCnt == CNT_FULL - 1'b1);
    strobe.outStart = ~csIdle && fallEdge && (bitCnt == CNT_HDR);
    strobe.outShift = ~csIdle && fallEdge && (bitCnt > CNT_HDR) && (bitCnt < CNT_FULL);
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!pdnN)
    (bitCnt == CNT_FULL) |=> (bitCnt == CNT_FULL) || (bitCnt == '0)); // R12

endmodule

// File: rtl/hrp_regs.sv
module hrp_regs #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 10,
  parameter int RSVD_ADDR  = 1,
  parameter int MODE_REG   = 2,
  parameter int MODE_BIT   = 2
) (
  input  logic                       clk,
  input  logic                       pdnN,
  input  hrp_pkg::hrpStrobe_t        strobe,
  output logic [NUM_REGS*DATA_W-1:0] regFlat,
  output logic                       sdo,
  output logic                       sdoOe
);
  localparam int HDR_BITS   = 3 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;

  logic [FRAME_BITS-2:0] frameSr;
  logic [HDR_BITS-1:0]   hdrNow;
  logic [FRAME_BITS-1:0] wordNow;
  logic [1:0]            rdChip, wrChip;
  logic                  rdRw, wrRw, mode3, rdOk, wrHdrOk, wrHit, readGo;
  logic [ADDR_W-1:0]     rdAddr, wrAddr;
  logic [DATA_W-1:0]     wrData, rdByte, outSr;

  assign hdrNow  = {frameSr[HDR_BITS-2:0], strobe.bitIn};
  assign wordNow = {frameSr, strobe.bitIn};

  assign rdChip = hdrNow[HDR_BITS-1 -: 2];
  assign rdRw   = hdrNow[ADDR_W];
  assign rdAddr = hdrNow[ADDR_W-1:0];
  assign wrChip = wordNow[FRAME_BITS-1 -: 2];
  assign wrRw   = wordNow[FRAME_BITS-3];
  assign wrAddr = wordNow[DATA_W +: ADDR_W];
  assign wrData = wordNow[DATA_W-1:0];

  assign mode3   = regFlat[MODE_REG*DATA_W + MODE_BIT];
  assign wrHdrOk = mode3 ? ({wrChip, wrRw} == hrp_pkg::WRONLY_HEADER)
                         : ((wrChip == hrp_pkg::CHIP_CODE) && wrRw);
  assign rdOk    = !mode3 && (rdChip == hrp_pkg::CHIP_CODE) && !rdRw;
  assign wrHit   = strobe.atEnd && wrHdrOk;

  always_ff @(posedge clk or negedge pdnN) begin
    if (!pdnN)               frameSr <= '0;
    else if (strobe.shiftIn) frameSr <= wordNow[FRAME_BITS-2:0];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    if (i == RSVD_ADDR) begin : gRsvd
      assign regFlat[i*DATA_W +: DATA_W] = '0;
    end else begin : gStore
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge pdnN) begin
        if (!pdnN) q <= DATA_W'(hrp_pkg::regDefault(i));
        else if (wrHit && (wrAddr == ADDR_W'(i))) q <= wrData;
      end
      assign regFlat[i*DATA_W +: DATA_W] = q;
    end
  end

  always_comb begin
    rdByte = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rdAddr == ADDR_W'(i)) rdByte = regFlat[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge pdnN) begin
    if (!pdnN) begin
      readGo <= 1'b0;
      sdoOe  <= 1'b0;
      outSr  <= '0;
    end else if (strobe.clear) begin
      readGo <= 1'b0;
      sdoOe  <= 1'b0;
    end else begin
      if (strobe.atHeader) begin
        readGo <= rdOk;
        outSr  <= rdByte;
      end
      if (strobe.outStart && readGo) sdoOe <= 1'b1;
      if (strobe.outShift && sdoOe)  outSr <= {outSr[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo = sdoOe & outSr[DATA_W-1];

  AST_WRITE_AT_END: assert property (@(posedge clk) disable iff (!pdnN)
    !$stable(regFlat) |-> $past(strobe.atEnd)); // R3
  AST_QUIET_AFTER_CS: assert property (@(posedge clk) disable iff (!pdnN)
    strobe.clear |=> !sdoOe); // R5
  AST_SDO_FALL_ONLY: assert property (@(posedge clk) disable iff (!pdnN)
    (sdoOe && $past(sdoOe) && !$past(strobe.outShift)) |-> $stable(sdo)); // R4
  AST_NO_READ_WRONLY: assert property (@(posedge clk) disable iff (!pdnN)
    (mode3 && strobe.outStart) |=> !sdoOe); // R7

endmodule

// File: rtl/host_reg_port.sv
module host_reg_port #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 10,
  parameter int CS_BASE     = 4
) (
  input  logic                                clk,
  input  logic                                pdnN,
  input  logic                                csN,
  input  logic                                sclk,
  input  logic                                sdi,
  output logic                                sdo,
  output logic                                sdoOe,
  output logic [1:0]                          fmtSel,
  output logic                                powerOn,
  output logic                                runN,
  output logic                                wireMode3,
  output logic [1:0]                          inSel,
  output logic                                validity,
  output logic                                txEnable,
  output logic [(NUM_REGS-CS_BASE)*DATA_W-1:0] chanStatus
);
  localparam int FRAME_BITS = 3 + ADDR_W + DATA_W;
  localparam int HDR_BITS   = 3 + ADDR_W;

  hrp_pkg::hrpStrobe_t        strobe;
  logic [NUM_REGS*DATA_W-1:0] regFlat;
  logic                       unusedBits;

  hrp_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .FRAME_BITS(FRAME_BITS), .HEADER_BITS(HDR_BITS)
  ) uCtrl (
    .clk(clk), .pdnN(pdnN), .csN(csN), .sclk(sclk), .sdi(sdi), .strobe(strobe)
  );

  hrp_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .RSVD_ADDR(1), .MODE_REG(2), .MODE_BIT(2)
  ) uRegs (
    .clk(clk), .pdnN(pdnN), .strobe(strobe),
    .regFlat(regFlat), .sdo(sdo), .sdoOe(sdoOe)
  );

  assign runN       = regFlat[0];
  assign powerOn    = regFlat[1];
  assign fmtSel     = regFlat[3:2];
  assign inSel      = regFlat[2*DATA_W +: 2];
  assign wireMode3  = regFlat[2*DATA_W + 2];
  assign txEnable   = regFlat[3*DATA_W];
  assign validity   = regFlat[3*DATA_W + 1];
  assign chanStatus = regFlat[NUM_REGS*DATA_W-1 : CS_BASE*DATA_W];
  assign unusedBits = ^{regFlat[DATA_W-1:4], regFlat[2*DATA_W-1:DATA_W],
                        regFlat[3*DATA_W-1:2*DATA_W+3], regFlat[4*DATA_W-1:3*DATA_W+2]};

endmodule

// File: tb/host_reg_port_test.sv
module host_reg_port_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic pdnN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdoOe, powerOn, runN, wireMode3, validity, txEnable;
  logic [1:0] fmtSel, inSel;
  logic [47:0] chanStatus;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] model [32];

  always #2 clk = ~clk;

  host_reg_port uut (
    .clk(clk), .pdnN(pdnN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .fmtSel(fmtSel), .powerOn(powerOn), .runN(runN),
    .wireMode3(wireMode3), .inSel(inSel), .validity(validity),
    .txEnable(txEnable), .chanStatus(chanStatus)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] defOf(input int a);
    case (a)
      0: return 8'h8F;
      3: return 8'h81;
      4: return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit writable(input int a);
    return (a == 0) || (a >= 2 && a <= 9);
  endfunction

  task automatic resetModel();
    for (int a = 0; a < 32; a++) model[a] = defOf(a);
  endtask

  task automatic sendFrame(input logic [2:0] hdr, input logic [4:0] addr, input logic [7:0] data,
                           input int nClk, input bit keepCs,
                           output logic [7:0] rdVal, output bit oeEarly, output bit oeSeen);
    logic [15:0] word;
    word = {hdr, addr, data};
    rdVal = '0; oeEarly = 1'b0; oeSeen = 1'b0;
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nClk; i++) begin
      sdi = (i < 16) ? word[15-i] : 1'b1;
      waitClk(HALF);
      if (sdoOe) oeSeen = 1'b1;
      if (i <= 7 && sdoOe) oeEarly = 1'b1;
      if (i >= 8 && i <= 15) rdVal[15-i] = sdo;
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    waitClk(HALF);
    if (sdoOe) oeSeen = 1'b1;
    if (!keepCs) begin
      csN = 1'b1;
      waitClk(HALF);
    end
  endtask

  task automatic writeReg(input logic [2:0] hdr, input int a, input logic [7:0] d);
    logic [7:0] rv; bit e, s;
    sendFrame(hdr, 5'(a), d, 16, 1'b0, rv, e, s);
    check(!s, "R5 write frame drive", s, 0);
  endtask

  task automatic readCheck(input int a, input string req);
    logic [7:0] rv; bit e, s;
    sendFrame(3'b110, 5'(a), 8'h00, 16, 1'b0, rv, e, s);
    check(rv == model[a], req, rv, model[a]);
    check(!e, "R4 early drive", e, 0);
    check(!sdoOe, "R5 quiet after select", sdoOe, 0);
  endtask

  task automatic checkFields(input string req);
    check(fmtSel == model[0][3:2], req, fmtSel, model[0][3:2]);
    check(powerOn == model[0][1] && runN == model[0][0], req, {powerOn, runN}, model[0][1:0]);
    check(wireMode3 == model[2][2] && inSel == model[2][1:0], req,
          {wireMode3, inSel}, model[2][2:0]);
    check(validity == model[3][1] && txEnable == model[3][0], req,
          {validity, txEnable}, model[3][1:0]);
    check(chanStatus == {model[9], model[8], model[7], model[6], model[5], model[4]}, req,
          chanStatus, {model[9], model[8], model[7], model[6], model[5], model[4]});
  endtask

  initial begin
    logic [7:0] rv; bit e, s;
    resetModel();
    waitClk(5);
    check(!sdoOe, "R5 power-down quiet", sdoOe, 0);
    pdnN = 1'b1;
    waitClk(4);
    checkFields("R1 defaults at outputs");
    for (int a = 0; a < 32; a++) readCheck(a, "R1 default readback");

    // R2 / R8: sweep every address with a computed pattern
    for (int a = 0; a < 32; a++) begin
      logic [7:0] d;
      d = 8'((a * 29 + 83) & 255);
      if (a == 2) d = d & 8'hFB;
      writeReg(3'b111, a, d);
      if (writable(a)) model[a] = d;
    end
    for (int a = 0; a < 32; a++) readCheck(a, "R2 R8 sweep readback");
    checkFields("R11 field mapping");

    // R6: wrong chip code, either direction
    for (int c = 0; c < 3; c++) begin
      for (int rw = 0; rw < 2; rw++) begin
        sendFrame({2'(c), 1'(rw)}, 5'd5, 8'hA5, 16, 1'b0, rv, e, s);
        check(!s, "R6 no drive on foreign chip code", s, 0);
      end
    end
    readCheck(5, "R6 foreign frame ignored");

    // R3: frames cut short
    sendFrame(3'b111, 5'd6, 8'h3C, 15, 1'b0, rv, e, s);
    readCheck(6, "R3 15-clock frame discarded");
    sendFrame(3'b111, 5'd6, 8'h3C, 8, 1'b0, rv, e, s);
    readCheck(6, "R3 8-clock frame discarded");

    // R12: extra clocks after the 16th, extra bits are ones
    sendFrame(3'b111, 5'd7, 8'h96, 20, 1'b0, rv, e, s);
    model[7] = 8'h96;
    readCheck(7, "R12 extra clocks ignored");

    // R9: soft reset bit
    writeReg(3'b111, 0, 8'h8E);
    model[0] = 8'h8E;
    checkFields("R9 soft reset keeps others");
    check(runN == 1'b0, "R9 runN low", runN, 0);
    writeReg(3'b111, 8, 8'h5A);
    model[8] = 8'h5A;
    readCheck(8, "R9 writes accepted in soft reset");

    // R7: write-only mode
    writeReg(3'b111, 2, 8'h05);
    model[2] = 8'h05;
    checkFields("R7 enter write-only mode");
    writeReg(3'b111, 3, 8'h02);
    checkFields("R7 header 111 ignored");
    writeReg(3'b011, 3, 8'h02);
    model[3] = 8'h02;
    checkFields("R7 header 011 commits");
    sendFrame(3'b110, 5'd3, 8'h00, 16, 1'b0, rv, e, s);
    check(!s, "R7 read gives no drive", s, 0);
    writeReg(3'b011, 2, 8'h00);
    model[2] = 8'h00;
    readCheck(3, "R7 value after leaving write-only mode");

    // R10: power-down in the middle of a read frame
    sendFrame(3'b110, 5'd3, 8'h00, 12, 1'b1, rv, e, s);
    check(sdoOe == 1'b1, "R4 drive mid read", sdoOe, 1);
    pdnN = 1'b0;
    #1;
    check(!sdoOe, "R10 immediate quiet", sdoOe, 0);
    resetModel();
    checkFields("R10 defaults restored");
    csN = 1'b1;
    waitClk(HALF);
    sendFrame(3'b111, 5'd4, 8'hFF, 16, 1'b0, rv, e, s);
    check(!s, "R10 no drive in power-down", s, 0);
    checkFields("R10 writes blocked");
    pdnN = 1'b1;
    waitClk(4);
    readCheck(4, "R10 register after release");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule